// File: doc/BRIEF.md
# Reference-Compare Interval Timer

A bus-mapped timer that counts either every bus clock or once per sixteen bus clocks and compares its live count with a programmable reference value. A match is inclusive: the tick on which the count equals the reference raises an event flag. In restart mode that same tick returns the count to zero, so a reference of N gives a period of N+1 counts, and loading N-1 gives exactly N. With restart off, the count runs past the reference and wraps at its maximum.

A rising edge on an asynchronous capture pin is synchronised, latches the live count into a capture register and raises a capture flag. Each flag clears when software writes a one to its bit. A level interrupt output stays high while any flag is set whose interrupt-enable bit is also set. Software stops the timer by clearing the run bit, changes the setup, then sets the run bit again.

Register reads are combinational on `bus_rdata` for the current `bus_addr`. Writes take effect at the clock edge where `bus_en` and `bus_we` are both high.

Top module: `ref_interval_timer`

## Requirements
- R1: After reset the control register (address 0) reads 0, the reference register (address 1) reads all ones, count (address 2), flags (address 3) and capture (address 4) read 0, and `irq` is low.
- R2: With control bit0 (run) set and bit1 (slow) clear, the count rises by one on every clock.
- R3: With run and slow both set, the count rises by one once every 16 clocks.
- R4: With control bit2 (restart) set, a tick that finds the count equal to the reference loads 0. The count thus cycles from 0 to the reference inclusive, a period of reference+1 counts.
- R5: With restart clear, the count keeps rising past the reference and wraps from 2^REF_W-1 to 0.
- R6: Flag bit0 (reference flag) is set by any tick that finds the count equal to the reference, whether restart is set or clear.
- R7: While run is clear, the count and the prescaler are held at 0.
- R8: Writing address 3 clears each flag whose data bit is 1 (bit0 reference, bit1 capture). A 0 bit leaves its flag unchanged. An event in the same cycle as the clear keeps its flag set.
- R9: `irq` equals (flag bit0 AND control bit3) OR (flag bit1 AND control bit4), as a level.
- R10: A rising edge on `cap_in`, passed through a two-stage synchroniser, copies the current count into the capture register and sets flag bit1.
- R11: Reading the count at any time does not disturb counting. Addresses 2 and 4 ignore writes, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cap_in | input | 1 | Asynchronous capture request pin |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong count, prescaler phase or reference comparison shows at the count readback within one clock, or within 16 clocks in slow mode. It also moves the reference flag and `irq` by whole periods. A flag that fails to set or to clear shows on `irq` in the very next cycle whenever its enable bit is set, so `irq` is compared with the model on every clock. A capture synchroniser with the wrong depth latches a count that is off by one, which the capture register readback exposes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int PRE_DIV = 16;

    // control register layout, bit0 is run
    typedef struct packed {
        logic cap_ie;
        logic ref_ie;
        logic restart;
        logic slow;
        logic run;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic [ADDR_W-1:0] {
        A_CTL   = 3'd0,
        A_REF   = 3'd1,
        A_COUNT = 3'd2,
        A_FLAGS = 3'd3,
        A_CAPT  = 3'd4
    } reg_addr_e;

    localparam int FL_REF = 0;
    localparam int FL_CAP = 1;

    // flag update: a new event wins over a write-one clear
    function automatic logic flag_next(logic cur, logic evt, logic clr);
        return evt | (cur & ~clr);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic slow,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    assign tick = run & (~slow | (phase == LAST));

    always_ff @(posedge clk) begin
        if (rst || !run || !slow) begin
            phase <= '0;
        end else begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    // R3
    slow_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (run && slow && tick && $stable(slow)) |=> !tick || !slow);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         hit
);
    logic at_limit;

    assign at_limit = (count == limit);
    assign hit      = tick & at_limit;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count <= '0;
        end else if (tick) begin
            count <= (restart && at_limit) ? '0 : count + 1'b1;
        end
    end

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (count == '0));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !(restart && at_limit)) |=> (count == $past(count) + 1'b1));

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (run && hit && restart) |=> (count == '0));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !tick) |=> $stable(count));

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pin,
    input  logic [W-1:0] count,
    output logic [W-1:0] held,
    output logic         evt
);
    logic [2:0] sync_q;

    assign evt = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            held   <= '0;
        end else begin
            sync_q <= {sync_q[1:0], pin};
            if (evt) begin
                held <= count;
            end
        end
    end

    // R10
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> (held == $past(count)));

endmodule

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int REF_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        cap_in,
    output logic        irq
);
    import tmr_pkg::*;

    ctl_t             ctl;
    logic [REF_W-1:0] limit;
    logic [REF_W-1:0] count;
    logic [REF_W-1:0] held;
    logic             ref_fl, cap_fl;
    logic             tick, hit, cap_evt;
    logic             wr, clr_ref, clr_cap;

    assign wr      = bus_en & bus_we;
    assign clr_ref = wr && (bus_addr == A_FLAGS) && bus_wdata[FL_REF];
    assign clr_cap = wr && (bus_addr == A_FLAGS) && bus_wdata[FL_CAP];

    tmr_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst(rst), .run(ctl.run), .slow(ctl.slow), .tick(tick)
    );

    tmr_counter #(.W(REF_W)) u_cnt (
        .clk(clk), .rst(rst), .run(ctl.run), .tick(tick),
        .restart(ctl.restart), .limit(limit), .count(count), .hit(hit)
    );

    tmr_capture #(.W(REF_W)) u_cap (
        .clk(clk), .rst(rst), .pin(cap_in), .count(count),
        .held(held), .evt(cap_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            limit  <= '1;
            ref_fl <= 1'b0;
            cap_fl <= 1'b0;
        end else begin
            if (wr && bus_addr == A_CTL) begin
                ctl <= ctl_t'(bus_wdata[CTL_W-1:0]);
            end
            if (wr && bus_addr == A_REF) begin
                limit <= bus_wdata[REF_W-1:0];
            end
            ref_fl <= flag_next(ref_fl, hit, clr_ref);
            cap_fl <= flag_next(cap_fl, cap_evt, clr_cap);
        end
    end

    assign irq = (ref_fl & ctl.ref_ie) | (cap_fl & ctl.cap_ie);

    always_comb begin
        unique case (bus_addr)
            A_CTL:   bus_rdata = DATA_W'(ctl);
            A_REF:   bus_rdata = DATA_W'(limit);
            A_COUNT: bus_rdata = DATA_W'(count);
            A_FLAGS: bus_rdata = DATA_W'({cap_fl, ref_fl});
            A_CAPT:  bus_rdata = DATA_W'(held);
            default: bus_rdata = '0;
        endcase
    end

    // R6
    ref_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> ref_fl);

    // R8
    ref_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_ref && !hit) |=> !ref_fl);

    // R8
    cap_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_fl && !clr_cap) |=> cap_fl);

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl.ref_ie || ctl.cap_ie) |-> !irq);

endmodule

// File: tb/test_ref_interval_timer.sv
module test_ref_interval_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cap_in = 1'b0;
    logic        irq;

    int total = 0, bad = 0, cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ref_interval_timer #(.REF_W(16)) i_ref_interval_timer (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .irq(irq)
    );

    // behavioural model
    int m_cnt, m_pre, m_lim, m_ctl, m_cap;
    bit m_rf, m_cf;
    bit q1, q2, q3;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_pre = 0; m_lim = 'hFFFF; m_ctl = 0; m_cap = 0;
            m_rf = 0; m_cf = 0; q1 = 0; q2 = 0; q3 = 0;
        end else begin
            bit run, slow, stepped, matched, edge_seen, wr;
            int ncnt;
            run = m_ctl[0]; slow = m_ctl[1];
            stepped   = run && (!slow || m_pre == 15);
            matched   = stepped && (m_cnt == m_lim);
            edge_seen = q2 && !q3;
            wr        = bus_en && bus_we;
            if (edge_seen) m_cap = m_cnt;
            m_rf = matched   || (m_rf && !(wr && bus_addr == 3 && bus_wdata[0]));
            m_cf = edge_seen || (m_cf && !(wr && bus_addr == 3 && bus_wdata[1]));
            if (!run) ncnt = 0;
            else if (!stepped) ncnt = m_cnt;
            else if (m_ctl[2] && m_cnt == m_lim) ncnt = 0;
            else ncnt = (m_cnt + 1) % 65536;
            m_pre = (run && slow) ? (m_pre + 1) % 16 : 0;
            m_cnt = ncnt;
            if (wr && bus_addr == 0) m_ctl = int'(bus_wdata[4:0]);
            if (wr && bus_addr == 1) m_lim = int'(bus_wdata[15:0]);
            q3 = q2; q2 = q1; q1 = cap_in;
        end
    end

    function automatic int model_read(int a);
        case (a)
            0: return m_ctl;
            1: return m_lim;
            2: return m_cnt;
            3: return {m_cf, m_rf};
            4: return m_cap;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R9: interrupt level compared every cycle
    always @(negedge clk) begin
        if (!rst && !finished)
            check("R9 irq", irq, ((m_rf && m_ctl[3]) || (m_cf && m_ctl[4])) ? 1 : 0);
    end

    task automatic wr_reg(int a, int d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = 3'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_we = 0; bus_en = 0;
    endtask

    task automatic rd_model(int a, string tag);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = 3'(a);
        #1;
        check(tag, bus_rdata, model_read(a));
    endtask

    task automatic rd_const(int a, int exp, string tag);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = 3'(a);
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        while (!finished && cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<200000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset values
        rd_const(0, 0, "R1 ctl");
        rd_const(1, 'hFFFF, "R1 ref");
        rd_const(2, 0, "R1 count");
        rd_const(3, 0, "R1 flags");
        rd_const(4, 0, "R1 capture");
        rd_const(5, 0, "R11 unmapped");
        check("R1 irq", irq, 0);

        // R2 R4 R6 fast restart, reference 4
        wr_reg(1, 4);
        wr_reg(0, 'h0D);
        rd_const(2, 1, "R2 first step");
        for (int i = 0; i < 20; i++) rd_model(2, "R4 restart count");
        rd_model(3, "R6 ref flag");

        // R8 clear with a zero bit, then with a one bit
        wr_reg(3, 'h2);
        rd_model(3, "R8 zero bit keeps");
        wr_reg(3, 'h1);
        rd_model(3, "R8 one bit clears");

        // R11 writes to read-only addresses ignored
        wr_reg(2, 'h1234);
        rd_model(2, "R11 count write ignored");
        wr_reg(4, 'h55);
        rd_const(4, 0, "R11 capture write ignored");

        // R9 enable off masks irq
        wr_reg(0, 'h05);
        repeat (8) @(negedge clk);
        rd_model(3, "R9 flag with mask");

        // R7 stop
        wr_reg(0, 0);
        rd_const(2, 0, "R7 stopped");
        repeat (5) @(negedge clk);
        rd_const(2, 0, "R7 held");

        // R3 slow restart, reference 3
        wr_reg(1, 3);
        wr_reg(0, 'h0F);
        for (int i = 0; i < 140; i++) rd_model(2, "R3 slow count");
        rd_model(3, "R6 slow flag");

        // R10 capture
        wr_reg(3, 3);
        wr_reg(0, 'h11);
        repeat (7) @(negedge clk);
        cap_in = 1;
        repeat (3) @(negedge clk);
        cap_in = 0;
        repeat (3) @(negedge clk);
        rd_model(4, "R10 captured count");
        rd_model(3, "R10 capture flag");
        wr_reg(3, 2);
        rd_model(3, "R8 capture clear");

        // R5 no restart: wraps at full width
        wr_reg(0, 0);
        wr_reg(1, 2);
        wr_reg(0, 'h09);
        rd_model(2, "R5 count");
        v0 = int'(bus_rdata);
        repeat (65535) @(negedge clk);
        rd_const(2, v0, "R5 full wrap");
        rd_model(3, "R6 flag no restart");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule